// File: doc/BRIEF.md
# Double-Buffered PWM Channel with Two-Stage Clock Division

This block produces one pulse-width-modulated output from a fast source clock. The source clock first passes through a power-of-two divider and then through an integer prescaler. The resulting tick drives a period counter. Within each period the output sits at its active level for a programmed number of ticks and at the inactive level for the rest of the period.

Software programs the channel through a small write port. One 32-bit word packs the period length and the active length. That word lands in a shadow copy, and the running counter takes it up only when the current period ends. A ready flag tells software when the shadow can accept another word. The output polarity is also held in a shadow copy and switches at the same period edge, so a combined change of polarity and duty cannot produce a runt pulse. When the enable input is low, the channel is idle and its output rests at the inactive level.

Top module: `pwm_chan`

## Requirements
- R1: The tick lasts D = 2^M * (K+1) source clocks. M is control bits [3:0] and K is control bits [11:4]. An M value above 8 behaves exactly like M = 8.
- R2: One period spans P ticks, or 1 tick when P is 0. The period counter starts at 0 at the period start. The output is active while the counter is below A, so A = 0 gives a constant inactive level and A >= P gives a constant active level.
- R3: When the polarity bit is 1 the active level is high; when it is 0 the active level is low. The polarity bit is control bit [16].
- R4: A write to address 0 carries P in bits [31:16] and A in bits [15:0]. The new values reach the output only at the next period boundary.
- R5: After a write to address 0 is accepted, the ready output is low from the next cycle until the transfer to the working copy. Ready is high again in the cycle after that transfer.
- R6: A write to address 0 while ready is low is dropped, with no effect on the output at any later time.
- R7: A write to address 1 sets M and K at once. Its polarity bit takes effect at the next period boundary, which is the same boundary at which a pending period word is applied.
- R8: While enable is low, the output holds the inactive level, all counters are cleared, and any pending shadow values are transferred. The first enabled period starts with the counter at 0 and uses the latest values.
- R9: After reset, ready is 1 and the output is 0. The reset values are polarity 1, P = 0, A = 0, M = 0 and K = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Channel run enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the period word, 1 selects the control word |
| wr_data | input | 32 | Write data |
| rdy | output | 1 | Period shadow can accept a new word |
| pwm_out | output | 1 | Modulated output |

## Verification
A sweep covers small divider settings, both polarities, and duty patterns with A = 0, A between 0 and P, A equal to P, A above P, and P = 0. Each cycle of two full periods is compared with an arithmetic model, which separates errors in the tick length from errors in the counter wrap and in the compare edge. A run with the largest divider next to a run with an out-of-range M shows whether M is clamped. Mid-period writes check that a change waits for the boundary, that a write made while the shadow is busy is dropped, and that a combined polarity and duty change switches cleanly at one edge.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
    parameter int CNT_W = 16;
    parameter int M_W   = 4;
    parameter int K_W   = 8;
    parameter int M_MAX = 8;

    localparam logic ADDR_PERIOD = 1'b0;
    localparam logic ADDR_CTRL   = 1'b1;

    localparam int CTRL_K_LSB = M_W;
    localparam int CTRL_POL   = 16;

    typedef struct packed {
        logic [CNT_W-1:0] sh_per;
        logic [CNT_W-1:0] sh_act;
        logic             pend;
        logic             pol_sh;
        logic [CNT_W-1:0] per_w;
        logic [CNT_W-1:0] act_w;
        logic             pol_w;
        logic [M_W-1:0]   m;
        logic [K_W-1:0]   k;
    } shadow_st_t;

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } period_st_t;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_chan_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [M_W-1:0] m_sel,
    input  logic [K_W-1:0] k_val,
    output logic           tick
);
    localparam int S1_W = (M_MAX > 0) ? M_MAX : 1;

    typedef struct packed {
        logic [S1_W-1:0] c1;
        logic [K_W-1:0]  c2;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    t1;
    logic    t2;

    generate
        if (M_MAX > 0) begin : g_pow2
            logic [M_W-1:0] m_eff;
            logic [S1_W:0]  pow;
            logic [S1_W-1:0] lim1;
            always_comb begin
                m_eff = (m_sel > M_W'(M_MAX)) ? M_W'(M_MAX) : m_sel;
                pow   = (S1_W+1)'(1) << m_eff;
                lim1  = S1_W'(pow - (S1_W+1)'(1));
            end
            assign t1 = (st_q.c1 >= lim1);
        end else begin : g_nopow2
            assign t1 = 1'b1;
        end
    endgenerate

    assign t2   = (st_q.c2 >= k_val);
    assign tick = run && t1 && t2;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.c1 = '0;
            st_d.c2 = '0;
        end else begin
            st_d.c1 = t1 ? '0 : st_q.c1 + 1'b1;
            if (t1) begin
                st_d.c2 = t2 ? '0 : st_q.c2 + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
    import pwm_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [31:0]      wr_data,
    input  logic             boundary,
    input  logic             idle,
    output logic [CNT_W-1:0] per_w,
    output logic [CNT_W-1:0] act_w,
    output logic             pol_w,
    output logic [M_W-1:0]   m_val,
    output logic [K_W-1:0]   k_val,
    output logic             rdy
);
    localparam shadow_st_t ST_RST = '{
        sh_per: '0, sh_act: '0, pend: 1'b0, pol_sh: 1'b1,
        per_w: '0, act_w: '0, pol_w: 1'b1, m: '0, k: '0
    };

    shadow_st_t st_d, st_q;
    logic       load;

    assign load = boundary || idle;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.pol_w = st_q.pol_sh;
            if (st_q.pend) begin
                st_d.per_w = st_q.sh_per;
                st_d.act_w = st_q.sh_act;
                st_d.pend  = 1'b0;
            end
        end
        if (wr_en && (wr_addr == ADDR_PERIOD) && !st_q.pend) begin
            st_d.sh_per = wr_data[2*CNT_W-1:CNT_W];
            st_d.sh_act = wr_data[CNT_W-1:0];
            st_d.pend   = 1'b1;
        end
        if (wr_en && (wr_addr == ADDR_CTRL)) begin
            st_d.m      = wr_data[M_W-1:0];
            st_d.k      = wr_data[CTRL_K_LSB +: K_W];
            st_d.pol_sh = wr_data[CTRL_POL];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign per_w = st_q.per_w;
    assign act_w = st_q.act_w;
    assign pol_w = st_q.pol_w;
    assign m_val = st_q.m;
    assign k_val = st_q.k;
    assign rdy   = !st_q.pend;
endmodule

// File: rtl/pwm_period_counter.sv
module pwm_period_counter
    import pwm_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [CNT_W-1:0] per_w,
    input  logic [CNT_W-1:0] act_w,
    input  logic             pol_w,
    output logic             run,
    output logic             boundary,
    output logic [CNT_W-1:0] cnt,
    output logic             pwm_out
);
    period_st_t       st_d, st_q;
    logic [CNT_W-1:0] per_eff;
    logic             last;
    logic             active;

    assign run      = st_q.run && en;
    assign per_eff  = (per_w == '0) ? CNT_W'(1) : per_w;
    assign last     = (st_q.cnt >= per_eff - CNT_W'(1));
    assign boundary = run && tick && last;
    assign active   = (st_q.cnt < act_w);

    always_comb begin
        st_d     = st_q;
        st_d.run = en;
        if (!run) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = last ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt     = st_q.cnt;
    assign pwm_out = run ? (pol_w ? active : !active) : !pol_w;
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_chan_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        wr_en,
    input  logic        wr_addr,
    input  logic [31:0] wr_data,
    output logic        rdy,
    output logic        pwm_out
);
    logic             tick;
    logic             run;
    logic             boundary;
    logic [CNT_W-1:0] per_w;
    logic [CNT_W-1:0] act_w;
    logic [CNT_W-1:0] cnt;
    logic             pol_w;
    logic [M_W-1:0]   m_val;
    logic [K_W-1:0]   k_val;

    pwm_shadow_regs i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .boundary (boundary),
        .idle     (!run),
        .per_w    (per_w),
        .act_w    (act_w),
        .pol_w    (pol_w),
        .m_val    (m_val),
        .k_val    (k_val),
        .rdy      (rdy)
    );

    pwm_prescaler i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .m_sel (m_val),
        .k_val (k_val),
        .tick  (tick)
    );

    pwm_period_counter i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .tick     (tick),
        .per_w    (per_w),
        .act_w    (act_w),
        .pol_w    (pol_w),
        .run      (run),
        .boundary (boundary),
        .cnt      (cnt),
        .pwm_out  (pwm_out)
    );
endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk
    import pwm_chan_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_addr,
    input logic             rdy,
    input logic             pwm_out,
    input logic             tick,
    input logic             run,
    input logic             boundary,
    input logic [CNT_W-1:0] per_w,
    input logic [CNT_W-1:0] cnt,
    input logic             pol_w
);
    // R5: an accepted period write makes the shadow busy
    p_rdy_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_PERIOD && rdy) |=> !rdy);

    // R5: ready returns after the transfer cycle
    p_rdy_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy && (boundary || !run)) |=> rdy);

    // R8: idle output sits at the inactive level
    p_idle_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (pwm_out == !pol_w));

    // R2: the output only moves on a tick while running
    p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$past(tick)) |-> $stable(pwm_out));

    // R2: the period counter stays inside the period
    p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < ((per_w == '0) ? CNT_W'(1) : per_w)));
endmodule

bind pwm_chan pwm_chan_chk i_pwm_chan_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .rdy      (rdy),
    .pwm_out  (pwm_out),
    .tick     (tick),
    .run      (run),
    .boundary (boundary),
    .per_w    (per_w),
    .cnt      (cnt),
    .pol_w    (pol_w)
);

// File: tb/test_pwm_chan.sv
`timescale 1ns/1ps
module test_pwm_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rdy;
    logic        pwm_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pwm_chan i_pwm_chan (
        .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rdy(rdy), .pwm_out(pwm_out)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] ctrl_word(input logic pol, input int k, input int m);
        return (32'(pol) << 16) | (32'(k & 255) << 4) | 32'(m & 15);
    endfunction

    function automatic logic exp_out(input int i, input int d, input int p, input int a, input logic pol);
        int pe = (p == 0) ? 1 : p;
        int c = (i / d) % pe;
        logic act = (c < a);
        return pol ? act : !act;
    endfunction

    task automatic wr(input logic addr, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic setup(input logic pol, input int k, input int m, input int p, input int a);
        @(negedge clk);
        en = 1'b0;
        wr(1'b1, ctrl_word(pol, k, m));
        wr(1'b0, {16'(p), 16'(a)});
        repeat (3) @(negedge clk);
        en = 1'b1;
    endtask

    task automatic run_cfg(input string req, input logic pol, input int k, input int m,
                           input int p, input int a);
        int errs = 0;
        int me = (m > 8) ? 8 : m;
        int d = (1 << me) * (k + 1);
        int pe = (p == 0) ? 1 : p;
        logic first_act = 1'b0;
        logic first_exp = 1'b0;
        setup(pol, k, m, p, a);
        for (int i = 0; i < 2 * pe * d; i++) begin
            @(negedge clk);
            if (pwm_out !== exp_out(i, d, p, a, pol)) begin
                if (errs == 0) begin
                    first_act = pwm_out;
                    first_exp = exp_out(i, d, p, a, pol);
                end
                errs++;
            end
        end
        total++;
        if (errs != 0) begin
            bad++;
            $display("FAIL %s pol=%0b k=%0d m=%0d p=%0d a=%0d actual=%0b expected=%0b (%0d cycles off)",
                     req, pol, k, m, p, a, first_act, first_exp, errs);
        end
    endtask

    initial begin
        int pp[7] = '{4, 4, 4, 4, 1, 3, 0};
        int aa[7] = '{0, 2, 4, 6, 1, 1, 0};
        logic [3:0] e1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset rdy", rdy, 1'b1);
        chk("R9 reset out", pwm_out, 1'b0);

        // R1 R2 R3 sweep
        for (int m = 0; m < 2; m++)
            for (int k = 0; k < 3; k++)
                for (int pl = 0; pl < 2; pl++)
                    for (int j = 0; j < 7; j++)
                        run_cfg("R1/R2/R3 sweep", 1'(pl), k, m, pp[j], aa[j]);

        // R1 clamp of M
        run_cfg("R1 m=8", 1'b1, 0, 8, 2, 1);
        run_cfg("R1 m=9 clamps", 1'b1, 0, 9, 2, 1);

        // R4 R5 R6 shadow behaviour, D = 1
        setup(1'b1, 0, 0, 4, 1);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(i < 4 ? "R4 old word until boundary" : "R6 dropped write / R4 new word",
                pwm_out, (i < 4) ? (i < 1) : 1'b1);
            chk((i == 2 || i == 3) ? "R5 rdy busy" : "R5 rdy free",
                rdy, !(i == 2 || i == 3));
            if (i == 1) begin
                wr_en = 1'b1; wr_addr = 1'b0; wr_data = {16'd2, 16'd2};
            end else if (i == 2) begin
                wr_en = 1'b1; wr_addr = 1'b0; wr_data = {16'd4, 16'd0};
            end else begin
                wr_en = 1'b0;
            end
        end

        // R7 combined polarity and duty change at one boundary
        setup(1'b1, 0, 0, 4, 2);
        e1 = 4'b1000;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R7 polarity at boundary", pwm_out,
                (i < 4) ? (i < 2) : e1[i-4]);
            if (i == 1) begin
                wr_en = 1'b1; wr_addr = 1'b1; wr_data = ctrl_word(1'b0, 0, 0);
            end else if (i == 2) begin
                wr_en = 1'b1; wr_addr = 1'b0; wr_data = {16'd4, 16'd3};
            end else begin
                wr_en = 1'b0;
            end
        end

        // R8 disable: polarity now 0, so inactive is high
        en = 1'b0;
        #1;
        chk("R8 disabled out", pwm_out, 1'b1);
        repeat (5) @(negedge clk);
        chk("R8 disabled out hold", pwm_out, 1'b1);
        chk("R8 rdy idle", rdy, 1'b1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule